// File: doc/BRIEF.md
# Sync-Referenced Sample Window Extractor

This block sits at the front of a video input path and picks a rectangular crop out of an incoming frame. It takes the raw vertical sync, horizontal sync and data-enable strobes, brings each to an active-high form using its own polarity bit, and finds the edges that set the frame and line origins. The vertical origin is the trailing edge of the active vsync pulse. The horizontal origin is an edge of hsync (leading or trailing, selectable) or the leading edge of data enable, depending on a reference-select bit. A line counter and a pixel counter measure position from those origins. The window flag goes high for every valid pixel inside the programmed offsets and lengths.

Line tracking is a three-state machine. `LN_NOSYNC` is entered at reset: no vertical origin has been seen and no line is valid. A vertical origin with no coincident horizontal origin moves any state to `LN_ARMED`, which waits for the first horizontal origin. A horizontal origin in `LN_ARMED` moves to `LN_COUNT` as line 0. A vertical origin together with a horizontal origin in the same cycle moves any state straight to `LN_COUNT` as line 0. In `LN_COUNT` each further horizontal origin advances the line number, saturating at its maximum. An optional one-stage vsync delay moves the vertical origin one cycle later. When vsync and hsync would otherwise land in the same cycle, this puts the hsync edge in the old frame.

Top module: `sync_window_crop`

## Requirements
- R1: While reset is held, and in the first cycle after its release, `win_active`, `frame_start` and `line_start` are 0. Until a vertical origin has been seen, `win_active` stays 0 whatever the horizontal strobes do.
- R2: Each strobe is active when its pin equals its polarity bit (1 = active high, 0 = active low). All edge detection uses the active form.
- R3: With the vsync delay off, a vertical origin is the first cycle in which active vsync is low after a cycle in which it was high. `frame_start` is 1 in the cycle after that sample.
- R4: With `ref_use_hs` = 0 the horizontal origin is the first cycle in which active DE is high after a low cycle, and hsync is ignored. With `ref_use_hs` = 1, DE is ignored.
- R5: With `ref_use_hs` = 1 the horizontal origin is the rising edge of active hsync when `hs_edge_first` = 1 and its falling edge when it is 0. `hs_edge_first` has no effect when DE is the reference.
- R6: `line_start` is 1 in the cycle after each horizontal origin. The pixel at a horizontal origin, if valid, has index 0. Each later valid pixel has the next index.
- R7: The first horizontal origin at or after a vertical origin starts line 0. Each later horizontal origin increments the line number.
- R8: `win_active` is 1 in the cycle after a sample exactly when that pixel is valid, its line number L satisfies v_off <= L < v_off + v_len, and its pixel index P satisfies h_off <= P < h_off + h_len. A zero length gives no window.
- R9: A cycle with `pix_valid` = 0 never raises `win_active` and does not advance the pixel index.
- R10: With `vs_delay_en` = 1 the vertical origin is recognised one cycle later than in R3. A horizontal origin in the cycle of the undelayed edge then belongs to the previous frame. With the delay off, a horizontal origin in the same cycle as the vertical origin starts line 0.
- R11: `frame_start` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| pix_valid | input | 1 | Pixel present in this cycle |
| vs_in | input | 1 | Raw vertical sync |
| hs_in | input | 1 | Raw horizontal sync |
| de_in | input | 1 | Raw data enable |
| vs_pol | input | 1 | Vsync polarity, 1 = active high |
| hs_pol | input | 1 | Hsync polarity, 1 = active high |
| de_pol | input | 1 | DE polarity, 1 = active high |
| ref_use_hs | input | 1 | Horizontal reference: 1 hsync, 0 DE |
| hs_edge_first | input | 1 | Hsync origin edge: 1 leading, 0 trailing |
| vs_delay_en | input | 1 | Delay vsync by one cycle |
| v_off | input | 12 | Vertical offset in lines |
| v_len | input | 12 | Window height in lines |
| h_off | input | 12 | Horizontal offset in pixels |
| h_len | input | 12 | Window width in pixels |
| win_active | output | 1 | Previous cycle's pixel is inside the window |
| frame_start | output | 1 | Vertical origin seen in previous cycle |
| line_start | output | 1 | Horizontal origin seen in previous cycle |

## Verification
The hardest case to reach is a vsync trailing edge and an hsync leading edge arriving in the very same cycle. Only that case separates the delayed and undelayed vsync paths and drives the direct `LN_NOSYNC`/`LN_ARMED` to `LN_COUNT` jump. The stimulus builds it on purpose: it releases vsync and raises hsync on the same clock, once with the delay off and once with it on. It then checks which line the coincident pixel is credited to and when `frame_start` arrives. The table pass runs whole frames under every reference and edge choice with mixed polarities, so the pixel origin moves between hsync edges and DE while the expected window is computed from line and position.

// File: rtl/swx_pkg.sv
`timescale 1ns/1ps
package swx_pkg;
    typedef enum logic [1:0] {
        LN_NOSYNC = 2'd0,
        LN_ARMED  = 2'd1,
        LN_COUNT  = 2'd2
    } ln_state_e;
endpackage

// File: rtl/swx_sync_cond.sv
`timescale 1ns/1ps
// Strobe conditioning: polarity, optional vsync delay, origin edges.
module swx_sync_cond #(
    parameter int VS_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_in,
    input  logic hs_in,
    input  logic de_in,
    input  logic vs_pol,
    input  logic hs_pol,
    input  logic de_pol,
    input  logic ref_use_hs,
    input  logic hs_edge_first,
    input  logic vs_delay_en,
    output logic v_origin,
    output logic h_origin
);
    logic vs_act, hs_act, de_act;
    logic vs_late, vs_used;
    logic vs_prev, hs_prev, de_prev;
    logic [VS_DLY-1:0] vs_pipe;

    assign vs_act = vs_pol ? vs_in : ~vs_in;
    assign hs_act = hs_pol ? hs_in : ~hs_in;
    assign de_act = de_pol ? de_in : ~de_in;

    generate
        if (VS_DLY == 1) begin : g_dly_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vs_pipe <= '0;
                else        vs_pipe <= vs_act;
            end
        end else begin : g_dly_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vs_pipe <= '0;
                else        vs_pipe <= {vs_pipe[VS_DLY-2:0], vs_act};
            end
        end
    endgenerate

    assign vs_late = vs_pipe[VS_DLY-1];
    assign vs_used = vs_delay_en ? vs_late : vs_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_prev <= 1'b0;
            hs_prev <= 1'b0;
            de_prev <= 1'b0;
        end else begin
            vs_prev <= vs_used;
            hs_prev <= hs_act;
            de_prev <= de_act;
        end
    end

    always_comb begin
        v_origin = vs_prev & ~vs_used;
        if (!ref_use_hs)        h_origin = de_act & ~de_prev;
        else if (hs_edge_first) h_origin = hs_act & ~hs_prev;
        else                    h_origin = hs_prev & ~hs_act;
    end
endmodule

// File: rtl/swx_line_fsm.sv
`timescale 1ns/1ps
// Frame phase state machine with line counter and vertical range test.
module swx_line_fsm
    import swx_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_origin,
    input  logic              h_origin,
    input  logic [LINE_W-1:0] v_off,
    input  logic [LINE_W-1:0] v_len,
    output logic              row_hit
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    ln_state_e         state_q, state_d;
    logic [LINE_W-1:0] line_q, line_now;
    logic              line_ok;
    logic [LINE_W:0]   v_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_NOSYNC;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (line_ok) line_q <= line_now;
        end
    end

    always_comb begin
        state_d = state_q;
        if (v_origin) begin
            state_d = h_origin ? LN_COUNT : LN_ARMED;
        end else begin
            unique case (state_q)
                LN_NOSYNC: state_d = LN_NOSYNC;
                LN_ARMED:  if (h_origin) state_d = LN_COUNT;
                LN_COUNT:  state_d = LN_COUNT;
                default:   state_d = LN_NOSYNC;
            endcase
        end
    end

    always_comb begin
        line_ok  = 1'b0;
        line_now = line_q;
        if (v_origin) begin
            line_ok  = h_origin;
            line_now = '0;
        end else begin
            unique case (state_q)
                LN_ARMED: begin
                    if (h_origin) begin
                        line_ok  = 1'b1;
                        line_now = '0;
                    end
                end
                LN_COUNT: begin
                    line_ok = 1'b1;
                    if (h_origin && line_q != LINE_MAX) line_now = line_q + 1'b1;
                end
                default: line_ok = 1'b0;
            endcase
        end
    end

    assign v_end   = {1'b0, v_off} + {1'b0, v_len};
    assign row_hit = line_ok && (line_now >= v_off) && ({1'b0, line_now} < v_end);
endmodule

// File: rtl/swx_pix_count.sv
`timescale 1ns/1ps
// Pixel position counter and horizontal range test.
module swx_pix_count #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_origin,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] h_off,
    input  logic [PIX_W-1:0] h_len,
    output logic             col_hit
);
    localparam logic [PIX_W-1:0] PIX_MAX = '1;

    logic [PIX_W-1:0] pix_q, pix_now;
    logic [PIX_W:0]   h_end;

    assign pix_now = h_origin ? '0 : pix_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            pix_q <= '0;
        else if (pix_valid && pix_now != PIX_MAX) pix_q <= pix_now + 1'b1;
        else                                   pix_q <= pix_now;
    end

    assign h_end   = {1'b0, h_off} + {1'b0, h_len};
    assign col_hit = pix_valid && (pix_now >= h_off) && ({1'b0, pix_now} < h_end);
endmodule

// File: rtl/sync_window_crop.sv
`timescale 1ns/1ps
// Top: crops a rectangle from the incoming frame using sync-derived origins.
module sync_window_crop #(
    parameter int LINE_W = 12,
    parameter int PIX_W  = 12,
    parameter int VS_DLY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              vs_in,
    input  logic              hs_in,
    input  logic              de_in,
    input  logic              vs_pol,
    input  logic              hs_pol,
    input  logic              de_pol,
    input  logic              ref_use_hs,
    input  logic              hs_edge_first,
    input  logic              vs_delay_en,
    input  logic [LINE_W-1:0] v_off,
    input  logic [LINE_W-1:0] v_len,
    input  logic [PIX_W-1:0]  h_off,
    input  logic [PIX_W-1:0]  h_len,
    output logic              win_active,
    output logic              frame_start,
    output logic              line_start
);
    logic v_origin, h_origin, row_hit, col_hit;

    swx_sync_cond #(.VS_DLY(VS_DLY)) u_cond (
        .clk(clk), .rst_n(rst_n),
        .vs_in(vs_in), .hs_in(hs_in), .de_in(de_in),
        .vs_pol(vs_pol), .hs_pol(hs_pol), .de_pol(de_pol),
        .ref_use_hs(ref_use_hs), .hs_edge_first(hs_edge_first),
        .vs_delay_en(vs_delay_en),
        .v_origin(v_origin), .h_origin(h_origin)
    );

    swx_line_fsm #(.LINE_W(LINE_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .v_origin(v_origin), .h_origin(h_origin),
        .v_off(v_off), .v_len(v_len),
        .row_hit(row_hit)
    );

    swx_pix_count #(.PIX_W(PIX_W)) u_pixels (
        .clk(clk), .rst_n(rst_n),
        .h_origin(h_origin), .pix_valid(pix_valid),
        .h_off(h_off), .h_len(h_len),
        .col_hit(col_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_active  <= 1'b0;
            frame_start <= 1'b0;
            line_start  <= 1'b0;
        end else begin
            win_active  <= row_hit & col_hit;
            frame_start <= v_origin;
            line_start  <= h_origin;
        end
    end
endmodule

// File: rtl/swx_checker.sv
`timescale 1ns/1ps
// Port-level temporal checks, bound into the top module.
module swx_checker (
    input logic clk,
    input logic rst_n,
    input logic pix_valid,
    input logic vs_in,
    input logic hs_in,
    input logic de_in,
    input logic vs_pol,
    input logic hs_pol,
    input logic de_pol,
    input logic ref_use_hs,
    input logic hs_edge_first,
    input logic vs_delay_en,
    input logic win_active,
    input logic frame_start,
    input logic line_start
);
    logic [1:0] age;
    logic       warm;
    logic       vsn, hsn, den;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assign warm = (age == 2'd3);
    assign vsn  = (vs_in == vs_pol);
    assign hsn  = (hs_in == hs_pol);
    assign den  = (de_in == de_pol);

    p_win_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> $past(pix_valid));

    p_fs_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    p_fs_trailing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && frame_start && !$past(vs_delay_en) && !$past(vs_delay_en, 2)
         && $past(vs_pol) == $past(vs_pol, 2))
        |-> (!$past(vsn) && $past(vsn, 2)));

    p_fs_delayed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && frame_start && $past(vs_delay_en) && $past(vs_delay_en, 2)
         && $past(vs_pol) == $past(vs_pol, 2) && $past(vs_pol, 2) == $past(vs_pol, 3))
        |-> (!$past(vsn, 2) && $past(vsn, 3)));

    p_ls_hs_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && line_start && $past(ref_use_hs) && $past(hs_edge_first)
         && $past(hs_pol) == $past(hs_pol, 2))
        |-> ($past(hsn) && !$past(hsn, 2)));

    p_ls_de_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && line_start && !$past(ref_use_hs)
         && $past(de_pol) == $past(de_pol, 2))
        |-> ($past(den) && !$past(den, 2)));
endmodule

bind sync_window_crop swx_checker u_swx_checker (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
    .vs_in(vs_in), .hs_in(hs_in), .de_in(de_in),
    .vs_pol(vs_pol), .hs_pol(hs_pol), .de_pol(de_pol),
    .ref_use_hs(ref_use_hs), .hs_edge_first(hs_edge_first),
    .vs_delay_en(vs_delay_en),
    .win_active(win_active), .frame_start(frame_start), .line_start(line_start)
);

// File: tb/test_sync_window_crop.sv
`timescale 1ns/1ps
module test_sync_window_crop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic        vs_in = 1'b0, hs_in = 1'b0, de_in = 1'b0;
    logic        vs_pol = 1'b1, hs_pol = 1'b1, de_pol = 1'b1;
    logic        ref_use_hs = 1'b1, hs_edge_first = 1'b1, vs_delay_en = 1'b0;
    logic [11:0] v_off = '0, v_len = '0, h_off = '0, h_len = '0;
    logic        win_active, frame_start, line_start;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sync_window_crop i_sync_window_crop (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .vs_in(vs_in), .hs_in(hs_in), .de_in(de_in),
        .vs_pol(vs_pol), .hs_pol(hs_pol), .de_pol(de_pol),
        .ref_use_hs(ref_use_hs), .hs_edge_first(hs_edge_first),
        .vs_delay_en(vs_delay_en),
        .v_off(v_off), .v_len(v_len), .h_off(h_off), .h_len(h_len),
        .win_active(win_active), .frame_start(frame_start), .line_start(line_start)
    );

    typedef struct packed {
        logic [3:0] voff;
        logic [3:0] vlen;
        logic [3:0] hoff;
        logic [3:0] hlen;
        logic       vsp;
        logic       hsp;
        logic       dep;
        logic       refhs;
        logic       first;
        logic       dly;
    } row_t;

    localparam int NROWS = 6;
    localparam int LP    = 14;
    localparam int NL    = 6;
    localparam row_t TBL [NROWS] = '{
        '{4'd0, 4'd2, 4'd0, 4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd1, 4'd3, 4'd2, 4'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd2, 4'd2, 4'd1, 4'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{4'd0, 4'd6, 4'd3, 4'd8,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd4, 4'd5, 4'd0, 4'd14, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{4'd3, 4'd0, 4'd0, 4'd5,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive pins from active-high levels using the current polarity bits (R2)
    task automatic set_act(input logic va, input logic ha, input logic da, input logic pv);
        vs_in     = vs_pol ? va : ~va;
        hs_in     = hs_pol ? ha : ~ha;
        de_in     = de_pol ? da : ~da;
        pix_valid = pv;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_act(1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    int ln, px;

    task automatic model_cycle(input logic va, input logic ha, input logic da,
                               input logic vorg, input logic horg, input row_t c);
        logic exp_win;
        set_act(va, ha, da, 1'b1);
        tick();
        if (vorg) ln = -1;
        if (horg) begin
            px = 0;
            if (ln > -1000) ln = ln + 1;
        end
        exp_win = (ln >= 0) && (ln >= int'(c.voff)) && (ln < int'(c.voff) + int'(c.vlen))
                  && (px >= int'(c.hoff)) && (px < int'(c.hoff) + int'(c.hlen));
        chk(win_active, exp_win, "R7 R8 window");
        chk(frame_start, vorg, "R3 R11 frame_start");
        chk(line_start, horg, c.refhs ? "R5 R6 line_start" : "R4 R6 line_start");
        px = px + 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // ---- table of frame configurations ----
        for (int r = 0; r < NROWS; r++) begin
            row_t c;
            int korg;
            c = TBL[r];
            vs_pol = c.vsp; hs_pol = c.hsp; de_pol = c.dep;
            ref_use_hs = c.refhs; hs_edge_first = c.first; vs_delay_en = c.dly;
            v_off = 12'(c.voff); v_len = 12'(c.vlen);
            h_off = 12'(c.hoff); h_len = 12'(c.hlen);
            do_reset();
            ln = -1000;
            px = 1000;
            korg = c.refhs ? (c.first ? 0 : 2) : 4;
            for (int f = 0; f < 2; f++) begin
                for (int p = 0; p < 4; p++)
                    model_cycle(p < 2, 1'b0, 1'b0, p == 2 + int'(c.dly), 1'b0, c);
                for (int l = 0; l < NL; l++)
                    for (int k = 0; k < LP; k++)
                        model_cycle(1'b0, k < 2, (k >= 4) && (k < 12), 1'b0, k == korg, c);
            end
        end

        // ---- R1: reset state, and no window before any vertical origin ----
        vs_pol = 1'b1; hs_pol = 1'b1; de_pol = 1'b1;
        ref_use_hs = 1'b1; hs_edge_first = 1'b1; vs_delay_en = 1'b0;
        v_off = 12'd0; v_len = 12'd4; h_off = 12'd0; h_len = 12'd20;
        rst_n = 1'b0;
        set_act(1'b0, 1'b0, 1'b0, 1'b0);
        repeat (2) tick();
        chk(win_active, 1'b0, "R1 win in reset");
        chk(frame_start, 1'b0, "R1 frame_start in reset");
        chk(line_start, 1'b0, "R1 line_start in reset");
        rst_n = 1'b1;
        set_act(1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        chk(win_active, 1'b0, "R1 win first cycle");
        chk(frame_start, 1'b0, "R1 frame_start first cycle");
        for (int i = 0; i < 10; i++) begin
            set_act(1'b0, (i % 4) == 0, 1'b0, 1'b1);
            tick();
            chk(win_active, 1'b0, "R1 no window without vsync");
        end

        // ---- R2: vsync active high while pin idles high; hsync active low ----
        vs_pol = 1'b1; hs_pol = 1'b0;
        do_reset();
        vs_in = 1'b1; hs_in = 1'b1; de_in = 1'b0; pix_valid = 1'b1;
        repeat (3) begin
            tick();
            chk(frame_start, 1'b0, "R2 vsync high is active");
            chk(line_start, 1'b0, "R2 hsync high is idle");
        end
        vs_in = 1'b0;
        tick();
        chk(frame_start, 1'b1, "R2 R3 fall of active-high vsync is trailing");
        hs_in = 1'b0;
        tick();
        chk(frame_start, 1'b0, "R2 R11 frame_start single");
        chk(line_start, 1'b1, "R2 active-low hsync leading edge");

        // ---- R9: invalid pixel neither windows nor advances the index ----
        vs_pol = 1'b1; hs_pol = 1'b1; de_pol = 1'b1;
        ref_use_hs = 1'b1; hs_edge_first = 1'b1; vs_delay_en = 1'b0;
        v_off = 12'd0; v_len = 12'd1; h_off = 12'd1; h_len = 12'd2;
        do_reset();
        set_act(1'b1, 1'b0, 1'b0, 1'b1); tick();
        set_act(1'b0, 1'b0, 1'b0, 1'b1); tick();
        set_act(1'b0, 1'b1, 1'b0, 1'b1); tick();
        chk(win_active, 1'b0, "R9 pixel 0 outside");
        set_act(1'b0, 1'b0, 1'b0, 1'b0); tick();
        chk(win_active, 1'b0, "R9 invalid pixel");
        set_act(1'b0, 1'b0, 1'b0, 1'b1); tick();
        chk(win_active, 1'b1, "R9 pixel 1 inside");
        tick();
        chk(win_active, 1'b1, "R9 pixel 2 inside");
        tick();
        chk(win_active, 1'b0, "R9 pixel 3 outside");

        // ---- R10: coincident vsync trailing and hsync leading, delay off ----
        v_off = 12'd0; v_len = 12'd1; h_off = 12'd0; h_len = 12'd1;
        vs_delay_en = 1'b0;
        do_reset();
        set_act(1'b1, 1'b0, 1'b0, 1'b1); tick();
        set_act(1'b0, 1'b1, 1'b0, 1'b1); tick();
        chk(frame_start, 1'b1, "R10 frame_start no delay");
        chk(line_start, 1'b1, "R10 line_start coincident");
        chk(win_active, 1'b1, "R10 coincident edge starts line 0");
        set_act(1'b0, 1'b0, 1'b0, 1'b1); tick();
        chk(win_active, 1'b0, "R10 pixel 1 outside");

        // ---- R10: same stimulus with the delay on ----
        vs_delay_en = 1'b1;
        do_reset();
        set_act(1'b1, 1'b0, 1'b0, 1'b1); tick();
        set_act(1'b0, 1'b1, 1'b0, 1'b1); tick();
        chk(frame_start, 1'b0, "R10 delayed vsync not yet");
        chk(win_active, 1'b0, "R10 coincident hsync belongs to old frame");
        set_act(1'b0, 1'b0, 1'b0, 1'b1); tick();
        chk(frame_start, 1'b1, "R10 delayed frame_start");
        chk(win_active, 1'b0, "R10 armed no window");
        set_act(1'b0, 1'b1, 1'b0, 1'b1); tick();
        chk(line_start, 1'b1, "R10 next hsync origin");
        chk(win_active, 1'b1, "R10 next hsync starts line 0");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule